// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the execute stage of a small 32-bit load/store core. It takes a 4-bit operation code, a first operand read from a register, and a second operand. The second operand is either another register value or an 8-bit immediate that is widened with zeros. It returns a 32-bit result and a write enable for the destination register. Each cycle it may also update a registered set of four status flags: negative, zero, carry and overflow.

The operation set covers forward and reverse subtraction, each with and without the carry flag. It also has addition with and without carry, four bitwise operations (including a bit-clear), move and move-inverted, and two compare forms that only touch the flags. The result path is purely combinational. The flag register is written on the rising clock edge when the operation is a compare, or when the caller asks for flag update on any other valid operation. Carry-consuming operations read the flags held from earlier operations.

Top module: `dp_alu_core`

## Requirements
- R1: When `op2_imm_sel` is 1, the second operand is `{24'b0, op2_imm}` and `op2_reg` has no effect. A MOV (code 11) then yields exactly that value.
- R2: ADD (code 4) yields first + second. ADC (code 5) yields first + second + C. Both are taken modulo 2^32.
- R3: SUB (2) yields first − second and RSB (3) yields second − first. SBC (6) yields first − second − (1 − C) and RSC (7) yields second − first − (1 − C).
- R4: AND (0), ORR (10), EOR (1) and BIC (12) yield first&second, first|second, first^second and first&~second.
- R5: MOV (11) yields the second operand and MVN (13) yields its bitwise inverse. The first operand has no effect on either.
- R6: `rd_we` is 0 for CMP (8), CMN (9) and the reserved codes 14 and 15, and 1 for every other code. The result is 0 for the reserved codes.
- R7: On a flag update, N takes bit 31 of the operation's value and Z is 1 exactly when that value is zero. CMP uses first − second for this value and CMN uses first + second.
- R8: On a flag update by an arithmetic operation, C is the carry out of the addition. For a subtraction C is 1 when no borrow occurs. V is signed two's-complement overflow.
- R9: On a flag update by a bitwise or move operation, C and V keep their previous values.
- R10: The flags change only on a clock edge where the code is CMP or CMN, or where `set_flags` is 1 with a non-reserved code. Otherwise all four keep their values.
- R11: With `rst` high at a clock edge, all four flags become 0.

Reset polarity: `rst` is active high and synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op_code | input | 4 | Operation code |
| rn_val | input | 32 | First operand |
| op2_reg | input | 32 | Register form of the second operand |
| op2_imm | input | 8 | Immediate form of the second operand |
| op2_imm_sel | input | 1 | 1 selects the immediate, 0 the register |
| set_flags | input | 1 | Request flag update for non-compare operations |
| result | output | 32 | Operation result, combinational |
| rd_we | output | 1 | Destination register write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The checker assumes that all inputs are known and stable across each rising edge. Its flag properties compare the registered flags with the previous cycle's inputs and result, so they rely on the inputs not changing at the edge. The bench changes every input on the falling edge and only reads outputs well clear of the rising edge. It sweeps all sixteen codes over a grid of boundary operand values with both operand sources and both flag-request settings. This lets the carry flag feed carry-consuming operations from both states.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_EOR  = 4'd1,
      OP_SUB  = 4'd2,
      OP_RSB  = 4'd3,
      OP_ADD  = 4'd4,
      OP_ADC  = 4'd5,
      OP_SBC  = 4'd6,
      OP_RSC  = 4'd7,
      OP_CMP  = 4'd8,
      OP_CMN  = 4'd9,
      OP_ORR  = 4'd10,
      OP_MOV  = 4'd11,
      OP_BIC  = 4'd12,
      OP_MVN  = 4'd13,
      OP_RS14 = 4'd14,
      OP_RS15 = 4'd15
   } dpa_op_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } dpa_cin_e;

   typedef struct packed {
      logic     valid;
      logic     arith;
      logic     wr;
      logic     force_upd;
      logic     swap;
      logic     invert;
      dpa_cin_e cin_mode;
   } dpa_ctl_t;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } dpa_flags_t;

endpackage

// File: rtl/dpa_decode.sv
module dpa_decode
   import dpa_pkg::*;
(
   input  logic [3:0] op_code,
   output dpa_ctl_t   ctl
);

   always_comb begin
      ctl           = '0;
      ctl.cin_mode  = CIN_ZERO;
      ctl.valid     = 1'b1;
      ctl.wr        = 1'b1;
      unique case (dpa_op_e'(op_code))
         OP_ADD: ctl.arith = 1'b1;
         OP_ADC: begin
            ctl.arith    = 1'b1;
            ctl.cin_mode = CIN_FLAG;
         end
         OP_SUB: begin
            ctl.arith    = 1'b1;
            ctl.invert   = 1'b1;
            ctl.cin_mode = CIN_ONE;
         end
         OP_SBC: begin
            ctl.arith    = 1'b1;
            ctl.invert   = 1'b1;
            ctl.cin_mode = CIN_FLAG;
         end
         OP_RSB: begin
            ctl.arith    = 1'b1;
            ctl.swap     = 1'b1;
            ctl.invert   = 1'b1;
            ctl.cin_mode = CIN_ONE;
         end
         OP_RSC: begin
            ctl.arith    = 1'b1;
            ctl.swap     = 1'b1;
            ctl.invert   = 1'b1;
            ctl.cin_mode = CIN_FLAG;
         end
         OP_CMP: begin
            ctl.arith     = 1'b1;
            ctl.invert    = 1'b1;
            ctl.cin_mode  = CIN_ONE;
            ctl.wr        = 1'b0;
            ctl.force_upd = 1'b1;
         end
         OP_CMN: begin
            ctl.arith     = 1'b1;
            ctl.wr        = 1'b0;
            ctl.force_upd = 1'b1;
         end
         OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: ctl.arith = 1'b0;
         default: begin
            ctl.valid = 1'b0;
            ctl.wr    = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dpa_operand_sel.sv
module dpa_operand_sel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic [DATA_W-1:0] reg_val,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic              imm_sel,
   output logic [DATA_W-1:0] opnd
);

   localparam int PAD_W = DATA_W - IMM_W;

   generate
      if (IMM_W >= DATA_W) begin : g_bad_imm
         $error("dpa_operand_sel: IMM_W must be narrower than DATA_W");
      end
      if (IMM_W < 1) begin : g_bad_imm_min
         $error("dpa_operand_sel: IMM_W must be at least 1");
      end
   endgenerate

   assign opnd = imm_sel ? {{PAD_W{1'b0}}, imm_val} : reg_val;

endmodule

// File: rtl/dpa_adder.sv
module dpa_adder #(
   parameter int DATA_W      = 32,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("dpa_adder: DATA_W must be at least 4");
      end

      if (SPLIT_CARRY) begin : g_csel
         logic [LO_W:0] lo_sum;
         logic [HI_W:0] hi_sum0;
         logic [HI_W:0] hi_sum1;
         logic [HI_W:0] hi_pick;

         assign lo_sum  = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
         assign hi_sum0 = {1'b0, x[DATA_W-1:LO_W]} + {1'b0, y[DATA_W-1:LO_W]};
         assign hi_sum1 = {1'b0, x[DATA_W-1:LO_W]} + {1'b0, y[DATA_W-1:LO_W]}
                          + {{HI_W{1'b0}}, 1'b1};
         assign hi_pick = lo_sum[LO_W] ? hi_sum1 : hi_sum0;
         assign sum     = {hi_pick[HI_W-1:0], lo_sum[LO_W-1:0]};
         assign cout    = hi_pick[HI_W];
      end else begin : g_flat
         logic [DATA_W:0] full;

         assign full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
         assign sum  = full[DATA_W-1:0];
         assign cout = full[DATA_W];
      end
   endgenerate

   assign ovf = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);

endmodule

// File: rtl/dpa_logic_unit.sv
module dpa_logic_unit
   import dpa_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] out
);

   always_comb begin
      unique case (dpa_op_e'(op_code))
         OP_AND:  out = a & b;
         OP_ORR:  out = a | b;
         OP_EOR:  out = a ^ b;
         OP_BIC:  out = a & ~b;
         OP_MOV:  out = b;
         OP_MVN:  out = ~b;
         default: out = '0;
      endcase
   end

endmodule

// File: rtl/dpa_flag_reg.sv
module dpa_flag_reg
   import dpa_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       arith,
   input  dpa_flags_t nxt,
   output dpa_flags_t cur
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= '0;
      end else if (en) begin
         cur.n <= nxt.n;
         cur.z <= nxt.z;
         if (arith) begin
            cur.c <= nxt.c;
            cur.v <= nxt.v;
         end
      end
   end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
   import dpa_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IMM_W       = 8,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] op2_reg,
   input  logic [IMM_W-1:0]  op2_imm,
   input  logic              op2_imm_sel,
   input  logic              set_flags,
   output logic [DATA_W-1:0] result,
   output logic              rd_we,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);

   localparam int MSB = DATA_W - 1;

   dpa_ctl_t          ctl;
   dpa_flags_t        flags_q;
   dpa_flags_t        flags_d;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] add_x;
   logic [DATA_W-1:0] add_y_raw;
   logic [DATA_W-1:0] add_y;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;
   logic [DATA_W-1:0] logic_out;
   logic [DATA_W-1:0] op_value;
   logic              flag_en;

   dpa_decode u_decode (
      .op_code (op_code),
      .ctl     (ctl)
   );

   dpa_operand_sel #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_opsel (
      .reg_val (op2_reg),
      .imm_val (op2_imm),
      .imm_sel (op2_imm_sel),
      .opnd    (opnd_b)
   );

   assign add_x     = ctl.swap ? opnd_b : rn_val;
   assign add_y_raw = ctl.swap ? rn_val : opnd_b;
   assign add_y     = ctl.invert ? ~add_y_raw : add_y_raw;

   always_comb begin
      unique case (ctl.cin_mode)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = flags_q.c;
         default:  add_cin = 1'b0;
      endcase
   end

   dpa_adder #(
      .DATA_W      (DATA_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) u_adder (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   dpa_logic_unit #(
      .DATA_W (DATA_W)
   ) u_logic (
      .op_code (op_code),
      .a       (rn_val),
      .b       (opnd_b),
      .out     (logic_out)
   );

   assign op_value = ctl.arith ? add_sum : logic_out;
   assign result   = ctl.wr ? op_value : '0;
   assign rd_we    = ctl.wr;

   assign flags_d.n = op_value[MSB];
   assign flags_d.z = (op_value == '0);
   assign flags_d.c = add_cout;
   assign flags_d.v = add_ovf;
   assign flag_en   = ctl.valid && (ctl.force_upd || set_flags);

   dpa_flag_reg u_flags (
      .clk   (clk),
      .rst   (rst),
      .en    (flag_en),
      .arith (ctl.arith),
      .nxt   (flags_d),
      .cur   (flags_q)
   );

   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;

endmodule

// File: rtl/dpa_alu_checker.sv
module dpa_alu_checker
   import dpa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        op_code,
   input logic [DATA_W-1:0] rn_val,
   input logic [IMM_W-1:0]  op2_imm,
   input logic              op2_imm_sel,
   input logic              set_flags,
   input logic [DATA_W-1:0] result,
   input logic              rd_we,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_v
);

   logic is_cmp;
   logic is_rsv;
   logic is_bitwise;
   logic upd;

   assign is_cmp     = (op_code == OP_CMP) || (op_code == OP_CMN);
   assign is_rsv     = (op_code == OP_RS14) || (op_code == OP_RS15);
   assign is_bitwise = (op_code == OP_AND) || (op_code == OP_ORR) || (op_code == OP_EOR)
                    || (op_code == OP_BIC) || (op_code == OP_MOV) || (op_code == OP_MVN);
   assign upd        = !is_rsv && (is_cmp || set_flags);

   // R6: compare and reserved codes never write the destination
   p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
      (is_cmp || is_rsv) |-> !rd_we);

   // R6: every other code writes
   p_write_r6: assert property (@(posedge clk) disable iff (rst)
      !(is_cmp || is_rsv) |-> rd_we);

   // R1: immediate move has zero upper bits and carries the immediate
   p_imm_move_r1: assert property (@(posedge clk) disable iff (rst)
      (op2_imm_sel && op_code == OP_MOV) |-> (result == {{(DATA_W-IMM_W){1'b0}}, op2_imm}));

   // R5: move ignores first operand - result equals inverse of move-not of same operand
   p_mvn_imm_r5: assert property (@(posedge clk) disable iff (rst)
      (op2_imm_sel && op_code == OP_MVN) |-> (~result == {{(DATA_W-IMM_W){1'b0}}, op2_imm}));

   // R10: flags hold when no update is requested
   p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable({flag_n, flag_z, flag_c, flag_v}));

   // R9: bitwise updates keep carry and overflow
   p_keep_cv_r9: assert property (@(posedge clk) disable iff (rst)
      (is_bitwise && set_flags) |=> $stable({flag_c, flag_v}));

   // R7: N follows bit 31 of a written result on update
   p_neg_r7: assert property (@(posedge clk) disable iff (rst)
      (upd && rd_we) |=> (flag_n == $past(result[DATA_W-1])));

   // R7: Z follows a written result on update
   p_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (upd && rd_we) |=> (flag_z == ($past(result) == '0)));

   // R11: reset clears the flags
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

   // R5: move result does not depend on rn_val (first-operand inverse case)
   p_rn_unused_r5: assert property (@(posedge clk) disable iff (rst)
      (op2_imm_sel && op_code == OP_MOV && rn_val != '0) |-> (result[DATA_W-1:IMM_W] == '0));

endmodule

bind dp_alu_core dpa_alu_checker #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .op_code     (op_code),
   .rn_val      (rn_val),
   .op2_imm     (op2_imm),
   .op2_imm_sel (op2_imm_sel),
   .set_flags   (set_flags),
   .result      (result),
   .rd_we       (rd_we),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .flag_c      (flag_c),
   .flag_v      (flag_v)
);

// File: tb/dp_alu_core_tb.sv
`timescale 1ns/1ps
module dp_alu_core_tb_top;

   logic        clk;
   logic        rst;
   logic [3:0]  op_code;
   logic [31:0] rn_val;
   logic [31:0] op2_reg;
   logic [7:0]  op2_imm;
   logic        op2_imm_sel;
   logic        set_flags;
   logic [31:0] result;
   logic        rd_we;
   logic        flag_n;
   logic        flag_z;
   logic        flag_c;
   logic        flag_v;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [31:0] pats [7];

   // expected flags, tracked in the bench
   logic en, ez, ec, ev;

   dp_alu_core dut_i (
      .clk         (clk),
      .rst         (rst),
      .op_code     (op_code),
      .rn_val      (rn_val),
      .op2_reg     (op2_reg),
      .op2_imm     (op2_imm),
      .op2_imm_sel (op2_imm_sel),
      .set_flags   (set_flags),
      .result      (result),
      .rd_we       (rd_we),
      .flag_n      (flag_n),
      .flag_z      (flag_z),
      .flag_c      (flag_c),
      .flag_v      (flag_v)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (op %0d a %h b %h imm_sel %0b)",
                  tag, what, act, exp, op_code, rn_val, op2_reg, op2_imm_sel);
      end
   endtask

   // kind: 0 reserved, 1 bitwise/move, 2 arithmetic
   task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic cin, output logic [31:0] r, output logic we,
                        output int kind, output logic co, output logic vo,
                        output logic [31:0] val);
      logic [33:0] need;
      logic [32:0] wide;
      logic [31:0] s, m;
      bit          sub;
      we = 1'b1; kind = 2; co = 1'b0; vo = 1'b0; r = '0; val = '0;
      sub = 0; s = a; m = b;
      case (op)
         0:  begin kind = 1; val = a & b;  end
         1:  begin kind = 1; val = a ^ b;  end
         10: begin kind = 1; val = a | b;  end
         12: begin kind = 1; val = a & ~b; end
         11: begin kind = 1; val = b;      end
         13: begin kind = 1; val = ~b;     end
         4, 5, 9: begin
            wide = {1'b0, a} + {1'b0, b} + ((op == 5) ? {32'b0, cin} : 33'd0);
            val  = wide[31:0];
            co   = wide[32];
            vo   = (a[31] == b[31]) && (val[31] != a[31]);
         end
         2, 6, 8: begin sub = 1; s = a; m = b; end
         3, 7:    begin sub = 1; s = b; m = a; end
         default: begin kind = 0; we = 1'b0; end
      endcase
      if (sub) begin
         need = {2'b0, m} + (((op == 6) || (op == 7)) ? {33'b0, ~cin} : 34'd0);
         val  = s - m - (((op == 6) || (op == 7)) ? {31'b0, ~cin} : 32'd0);
         co   = ({2'b0, s} >= need);
         vo   = (s[31] != m[31]) && (val[31] != s[31]);
      end
      if (op == 8 || op == 9) we = 1'b0;
      if (we) r = val;
   endtask

   function automatic string res_tag(int op, bit isel);
      if (isel && op == 11) return "R1";
      case (op)
         4, 5:             return "R2";
         2, 3, 6, 7:       return "R3";
         0, 1, 10, 12:     return "R4";
         11, 13:           return "R5";
         default:          return "R6";
      endcase
   endfunction

   task automatic check_flags(input string tag);
      chk(tag, "flag_n", {31'b0, flag_n}, {31'b0, en});
      chk(tag, "flag_z", {31'b0, flag_z}, {31'b0, ez});
      chk(tag, "flag_c", {31'b0, flag_c}, {31'b0, ec});
      chk(tag, "flag_v", {31'b0, flag_v}, {31'b0, ev});
   endtask

   task automatic step(input int op, input logic [31:0] a, input logic [31:0] breg,
                       input bit isel, input bit sf);
      logic [31:0] b, r, val;
      logic        we, co, vo;
      int          kind;
      bit          upd;
      string       ftag;
      @(negedge clk);
      op_code     = op[3:0];
      rn_val      = a;
      op2_imm_sel = isel;
      op2_imm     = breg[7:0];
      op2_reg     = isel ? ~breg : breg;  // R1: register value must be ignored
      set_flags   = sf;
      b = isel ? {24'b0, breg[7:0]} : breg;
      model(op, a, b, ec, r, we, kind, co, vo, val);
      #1;
      chk(res_tag(op, isel), "result", result, r);
      chk("R6", "rd_we", {31'b0, rd_we}, {31'b0, we});
      upd = (kind != 0) && (op == 8 || op == 9 || sf);
      if (upd) begin
         en = val[31];
         ez = (val == 32'b0);
         if (kind == 2) begin ec = co; ev = vo; end
      end
      @(posedge clk);
      #1;
      if (!upd)           ftag = "R10";
      else if (kind == 1) ftag = "R9";
      else                ftag = "R8";
      chk("R7", "flag_n", {31'b0, flag_n}, {31'b0, en});
      chk("R7", "flag_z", {31'b0, flag_z}, {31'b0, ez});
      chk(ftag, "flag_c", {31'b0, flag_c}, {31'b0, ec});
      chk(ftag, "flag_v", {31'b0, flag_v}, {31'b0, ev});
   endtask

   initial begin
      #(4ns * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      pats[0] = 32'h0000_0000;
      pats[1] = 32'h0000_0001;
      pats[2] = 32'h7FFF_FFFF;
      pats[3] = 32'h8000_0000;
      pats[4] = 32'hFFFF_FFFF;
      pats[5] = 32'h1234_56F8;
      pats[6] = 32'hAAAA_5555;

      rst = 1'b1; op_code = 4'd0; rn_val = '0; op2_reg = '0; op2_imm = '0;
      op2_imm_sel = 1'b0; set_flags = 1'b0;
      en = 0; ez = 0; ec = 0; ev = 0;
      repeat (3) @(posedge clk);
      #1;
      check_flags("R11");
      @(negedge clk);
      rst = 1'b0;

      for (int op = 0; op < 16; op++)
         for (int ia = 0; ia < 7; ia++)
            for (int ib = 0; ib < 7; ib++)
               for (int m = 0; m < 4; m++)
                  step(op, pats[ia], pats[ib], m[0], m[1]);

      // carry-consuming operations from both carry states
      for (int cs = 0; cs < 2; cs++)
         for (int op = 5; op < 8; op++) begin
            step(8, cs ? 32'd5 : 32'd3, 32'd4, 1'b0, 1'b0);  // sets C per R8
            step(op, 32'h0000_0010, 32'h0000_0003, 1'b0, 1'b0);
         end

      // reset in mid-run clears flags (R11)
      step(8, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
      step(9, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      en = 0; ez = 0; ec = 0; ev = 0;
      check_flags("R11");
      @(negedge clk);
      rst = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule